// File: doc/BRIEF.md
# Disciplined Day-of-Year Time Clock

This block keeps the time of year to the microsecond. It holds a day number from 001 to 366, hours, minutes, seconds and a microsecond count, and it moves forward by one microsecond on each cycle where a 1 MHz tick enable is high. All carries from the microsecond field up through the day field take effect in the same clock cycle, so the outputs never show a half-updated time.

An external reference receiver supplies a once-per-second pulse and a seconds-aligned time value. This value is the time of year at that pulse. A pulse counts as valid when it arrives one second, within a small tolerance, after the previous pulse. On a valid pulse the clock loads the reference time, adjusted by a signed cable-delay offset in microseconds. If pulses stop arriving for one and a half seconds, the clock drops to freewheel and keeps counting from its own tick. Once two correctly spaced pulses are seen again, it locks again without any outside help. The leap-year input selects whether the year ends after day 365 or day 366.

Top module: `tod_disciplined_clock`

## Requirements
- R1: The microsecond field stays within 0 to US_PER_SEC-1. Each tick adds one. At US_PER_SEC-1 it returns to 0 and the seconds field advances on that same tick.
- R2: Seconds wrap from 59 to 0, minutes from 59 to 0 and hours from 23 to 0. Each wrap carries into the next field on the same tick, and 23:59:59 carries into the next day.
- R3: At the end of the last day, the day field returns to 001. The last day is 366 when leap_year_i is 1 and 365 when it is 0. A day number above 365 with leap_year_i at 0 also goes to 001 at its midnight.
- R4: After reset the time is day 001 00:00:00.000000 and locked_o is 0.
- R5: The number of ticks between two pulses counts the tick on the cycle of the later pulse. A pulse is valid only when a previous pulse is on record and this count lies within US_PER_SEC ± SYNC_TOL. The first pulse after reset or after a loss, and any pulse outside the window, load nothing and do not set locked_o.
- R6: A valid pulse with an offset of 0 or more loads the reference day/hour/minute/second and sets the microsecond field to the offset. The new values appear on the cycle after the pulse, and locked_o is 1 from then on.
- R7: A valid pulse with a negative offset loads the reference time minus one second, with borrows through every field, and sets the microsecond field to US_PER_SEC plus the offset. Day 001 00:00:00 borrows to 23:59:59 of the last day.
- R8: If no pulse arrives before the tick count since the last pulse reaches 1.5 × US_PER_SEC, locked_o drops to 0 on the edge where the count reaches that limit. The pulse record is cleared, and the time keeps counting.
- R9: After a loss, two pulses spaced as in R5 lock the clock again and load the time, with no other input needed.
- R10: In a cycle with tick_us_i low and no valid pulse, every time field holds its value.
- R11: When a valid pulse and a tick fall in the same cycle, the load wins, and the loaded time is not advanced by that tick.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_us_i | input | 1 | Microsecond tick enable |
| ref_pps_i | input | 1 | Once-per-second pulse from the reference, one cycle wide |
| ref_day_i | input | 9 | Reference day of year at the pulse (1..366) |
| ref_hour_i | input | 5 | Reference hour at the pulse |
| ref_min_i | input | 6 | Reference minute at the pulse |
| ref_sec_i | input | 6 | Reference second at the pulse |
| leap_year_i | input | 1 | 1: the year has 366 days |
| delay_ofs_i | input | OFS_W | Signed cable-delay offset in microseconds |
| day_o | output | 9 | Day of year |
| hour_o | output | 5 | Hours |
| min_o | output | 6 | Minutes |
| sec_o | output | 6 | Seconds |
| usec_o | output | US_W | Microseconds |
| locked_o | output | 1 | 1 while disciplined, 0 in freewheel |

## Verification
The range assertions on the time fields assume that the reference time fields are always legal: day 1 to 366, hour below 24, minute and second below 60. They also assume that the offset magnitude stays under one second. The stimulus takes reference values only from a fixed table of legal boundary times and uses offsets well inside ±US_PER_SEC. Pulses are always one cycle wide, and the bench always keeps the tick high during the counted gap between an arming pulse and a loading pulse, so the spacing the bench intends matches the spacing the design measures.

// File: rtl/tod_pkg.sv
package tod_pkg;

    typedef struct packed {
        logic [8:0] day;
        logic [4:0] hour;
        logic [5:0] min;
        logic [5:0] sec;
    } tod_sec_t;

    localparam tod_sec_t TOD_EPOCH = '{day: 9'd1, hour: 5'd0, min: 6'd0, sec: 6'd0};

    function automatic logic [8:0] last_day(input logic leap);
        return leap ? 9'd366 : 9'd365;
    endfunction

    // One second forward with all carries resolved at once.
    function automatic tod_sec_t sec_fwd(input tod_sec_t t, input logic leap);
        tod_sec_t r;
        r = t;
        if (t.sec != 6'd59) begin
            r.sec = t.sec + 6'd1;
        end else begin
            r.sec = 6'd0;
            if (t.min != 6'd59) begin
                r.min = t.min + 6'd1;
            end else begin
                r.min = 6'd0;
                if (t.hour != 5'd23) begin
                    r.hour = t.hour + 5'd1;
                end else begin
                    r.hour = 5'd0;
                    r.day  = (t.day >= last_day(leap)) ? 9'd1 : t.day + 9'd1;
                end
            end
        end
        return r;
    endfunction

    // One second back with all borrows resolved at once.
    function automatic tod_sec_t sec_back(input tod_sec_t t, input logic leap);
        tod_sec_t r;
        r = t;
        if (t.sec != 6'd0) begin
            r.sec = t.sec - 6'd1;
        end else begin
            r.sec = 6'd59;
            if (t.min != 6'd0) begin
                r.min = t.min - 6'd1;
            end else begin
                r.min = 6'd59;
                if (t.hour != 5'd0) begin
                    r.hour = t.hour - 5'd1;
                end else begin
                    r.hour = 5'd23;
                    r.day  = (t.day <= 9'd1) ? last_day(leap) : t.day - 9'd1;
                end
            end
        end
        return r;
    endfunction

endpackage

// File: rtl/tod_sync_qualifier.sv
module tod_sync_qualifier #(
    parameter int US_PER_SEC = 1_000_000,
    parameter int SYNC_TOL   = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic tick_i,
    input  logic pulse_i,
    output logic valid_o,
    output logic locked_o
);
    localparam int LOSS  = US_PER_SEC + US_PER_SEC / 2;
    localparam int GAP_W = $clog2(LOSS + 1);
    localparam int WIN_LO = US_PER_SEC - SYNC_TOL;
    localparam int WIN_HI = US_PER_SEC + SYNC_TOL;

    logic [GAP_W-1:0] gap_q, gap_d;
    logic             armed_q, locked_q;
    logic             in_win, expire;
    int               span;

    always_comb begin
        span    = int'(gap_q) + int'(tick_i);
        in_win  = (span >= WIN_LO) && (span <= WIN_HI);
        valid_o = pulse_i && armed_q && in_win;
        if (pulse_i)
            gap_d = '0;
        else if (tick_i && (int'(gap_q) != LOSS))
            gap_d = gap_q + GAP_W'(1);
        else
            gap_d = gap_q;
        expire = !pulse_i && (int'(gap_d) == LOSS);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            gap_q    <= '0;
            armed_q  <= 1'b0;
            locked_q <= 1'b0;
        end else begin
            gap_q <= gap_d;
            if (pulse_i)     armed_q <= 1'b1;
            else if (expire) armed_q <= 1'b0;
            if (valid_o)     locked_q <= 1'b1;
            else if (expire) locked_q <= 1'b0;
        end
    end

    assign locked_o = locked_q;

    // R8: a saturated gap means the reference is declared lost
    p_loss_unlocks_r8: assert property (@(posedge clk) disable iff (rst)
        (int'(gap_q) == LOSS) |-> !locked_q);

    // R5: lock is only ever gained on the cycle after an armed pulse
    p_lock_needs_pulse_r5: assert property (@(posedge clk) disable iff (rst)
        $rose(locked_q) |-> $past(pulse_i && armed_q));

    // R9: the gap restarts after every pulse
    p_gap_restart_r9: assert property (@(posedge clk) disable iff (rst)
        pulse_i |=> (gap_q == '0));

endmodule

// File: rtl/tod_load_calc.sv
module tod_load_calc
    import tod_pkg::*;
#(
    parameter int US_PER_SEC = 1_000_000,
    parameter int OFS_W      = 15,
    localparam int US_W      = $clog2(US_PER_SEC)
) (
    input  tod_sec_t                  ref_i,
    input  logic                      leap_i,
    input  logic signed [OFS_W-1:0]   ofs_i,
    output tod_sec_t                  ld_sec_o,
    output logic [US_W-1:0]           ld_us_o
);
    int ofs;

    always_comb begin
        ofs = int'(ofs_i);
        if (ofs < 0) begin
            ld_sec_o = sec_back(ref_i, leap_i);
            ld_us_o  = US_W'(US_PER_SEC + ofs);
        end else begin
            ld_sec_o = ref_i;
            ld_us_o  = US_W'(ofs);
        end
    end

endmodule

// File: rtl/tod_counter.sv
module tod_counter
    import tod_pkg::*;
#(
    parameter int US_PER_SEC = 1_000_000,
    localparam int US_W      = $clog2(US_PER_SEC),
    localparam int US_MAX    = US_PER_SEC - 1
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            tick_i,
    input  logic            load_i,
    input  logic            leap_i,
    input  tod_sec_t        ld_sec_i,
    input  logic [US_W-1:0] ld_us_i,
    output tod_sec_t        sec_o,
    output logic [US_W-1:0] us_o
);
    tod_sec_t        sec_q;
    logic [US_W-1:0] us_q;
    logic            us_wrap;

    assign us_wrap = (us_q == US_W'(US_MAX));

    always_ff @(posedge clk) begin
        if (rst) begin
            sec_q <= TOD_EPOCH;
            us_q  <= '0;
        end else if (load_i) begin
            sec_q <= ld_sec_i;
            us_q  <= ld_us_i;
        end else if (tick_i) begin
            if (us_wrap) begin
                us_q  <= '0;
                sec_q <= sec_fwd(sec_q, leap_i);
            end else begin
                us_q <= us_q + US_W'(1);
            end
        end
    end

    assign sec_o = sec_q;
    assign us_o  = us_q;

    // R1: microsecond field never leaves its range
    p_us_range_r1: assert property (@(posedge clk) disable iff (rst)
        int'(us_q) < US_PER_SEC);

    // R2: coarse fields stay legal (given legal reference values)
    p_field_range_r2: assert property (@(posedge clk) disable iff (rst)
        (sec_q.sec < 6'd60) && (sec_q.min < 6'd60) && (sec_q.hour < 5'd24)
        && (sec_q.day >= 9'd1) && (sec_q.day <= 9'd366));

    // R1: a plain tick adds one and leaves the coarse fields alone
    p_us_step_r1: assert property (@(posedge clk) disable iff (rst)
        (!load_i && tick_i && !us_wrap) |=>
            (us_q == $past(us_q) + US_W'(1)) && $stable(sec_q));

    // R2: the wrap tick carries into the seconds in the same cycle
    p_carry_same_cycle_r2: assert property (@(posedge clk) disable iff (rst)
        (!load_i && tick_i && us_wrap) |=> (us_q == '0) && (sec_q != $past(sec_q)));

    // R10: nothing moves without a tick or a load
    p_hold_r10: assert property (@(posedge clk) disable iff (rst)
        (!load_i && !tick_i) |=> $stable(us_q) && $stable(sec_q));

endmodule

// File: rtl/tod_disciplined_clock.sv
module tod_disciplined_clock
    import tod_pkg::*;
#(
    parameter int US_PER_SEC = 1_000_000,
    parameter int SYNC_TOL   = 2,
    parameter int OFS_W      = 15,
    localparam int US_W      = $clog2(US_PER_SEC)
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    tick_us_i,
    input  logic                    ref_pps_i,
    input  logic [8:0]              ref_day_i,
    input  logic [4:0]              ref_hour_i,
    input  logic [5:0]              ref_min_i,
    input  logic [5:0]              ref_sec_i,
    input  logic                    leap_year_i,
    input  logic signed [OFS_W-1:0] delay_ofs_i,
    output logic [8:0]              day_o,
    output logic [4:0]              hour_o,
    output logic [5:0]              min_o,
    output logic [5:0]              sec_o,
    output logic [US_W-1:0]         usec_o,
    output logic                    locked_o
);
    tod_sec_t        ref_time, ld_sec, cur_sec;
    logic [US_W-1:0] ld_us;
    logic            load;

    assign ref_time = '{day: ref_day_i, hour: ref_hour_i, min: ref_min_i, sec: ref_sec_i};

    tod_sync_qualifier #(.US_PER_SEC(US_PER_SEC), .SYNC_TOL(SYNC_TOL)) u_qual (
        .clk      (clk),
        .rst      (rst),
        .tick_i   (tick_us_i),
        .pulse_i  (ref_pps_i),
        .valid_o  (load),
        .locked_o (locked_o)
    );

    tod_load_calc #(.US_PER_SEC(US_PER_SEC), .OFS_W(OFS_W)) u_ldc (
        .ref_i    (ref_time),
        .leap_i   (leap_year_i),
        .ofs_i    (delay_ofs_i),
        .ld_sec_o (ld_sec),
        .ld_us_o  (ld_us)
    );

    tod_counter #(.US_PER_SEC(US_PER_SEC)) u_cnt (
        .clk      (clk),
        .rst      (rst),
        .tick_i   (tick_us_i),
        .load_i   (load),
        .leap_i   (leap_year_i),
        .ld_sec_i (ld_sec),
        .ld_us_i  (ld_us),
        .sec_o    (cur_sec),
        .us_o     (usec_o)
    );

    assign day_o  = cur_sec.day;
    assign hour_o = cur_sec.hour;
    assign min_o  = cur_sec.min;
    assign sec_o  = cur_sec.sec;

    // R6: a load always leaves the clock locked
    p_load_locks_r6: assert property (@(posedge clk) disable iff (rst)
        load |=> locked_o);

endmodule

// File: tb/tod_disciplined_clock_tb.sv
module tod_disciplined_clock_tb_top;

    localparam int US    = 50;
    localparam int TOL   = 2;
    localparam int OFS_W = 15;
    localparam int US_W  = $clog2(US);
    localparam int LOSS  = US + US / 2;
    localparam longint DAYLEN = 64'd86400 * US;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic tick = 1'b0;
    logic pps = 1'b0;
    logic [8:0] p_day = 9'd1;
    logic [4:0] p_hour = '0;
    logic [5:0] p_min = '0;
    logic [5:0] p_sec = '0;
    logic leap = 1'b0;
    logic signed [OFS_W-1:0] ofs = '0;
    logic [8:0] day_o;
    logic [4:0] hour_o;
    logic [5:0] min_o;
    logic [5:0] sec_o;
    logic [US_W-1:0] usec_o;
    logic locked_o;

    always #4 clk = ~clk;

    tod_disciplined_clock #(.US_PER_SEC(US), .SYNC_TOL(TOL), .OFS_W(OFS_W)) dut_i (
        .clk(clk), .rst(rst), .tick_us_i(tick), .ref_pps_i(pps),
        .ref_day_i(p_day), .ref_hour_i(p_hour), .ref_min_i(p_min), .ref_sec_i(p_sec),
        .leap_year_i(leap), .delay_ofs_i(ofs),
        .day_o(day_o), .hour_o(hour_o), .min_o(min_o), .sec_o(sec_o),
        .usec_o(usec_o), .locked_o(locked_o)
    );

    int n_vec = 0;
    int n_bad = 0;
    string cur_req = "R4";

    longint m_total = 0;
    bit     m_locked = 0;
    bit     m_armed = 0;
    int     m_gap = 0;

    function automatic longint preset_total();
        return ((longint'(p_day) - 1) * 86400 + longint'(p_hour) * 3600
                + longint'(p_min) * 60 + longint'(p_sec)) * US;
    endfunction

    function automatic int lastday();
        return leap ? 366 : 365;
    endfunction

    // Arithmetic reference of one clock edge, from the requirements.
    task automatic model_edge(input bit t, input bit s);
        int span;
        bit valid;
        longint nxt;
        span  = m_gap + (t ? 1 : 0);
        valid = s && m_armed && (span >= US - TOL) && (span <= US + TOL);
        if (valid) begin
            m_total = preset_total() + longint'(ofs);
            if (m_total < 0) m_total += longint'(lastday()) * DAYLEN;
        end else if (t) begin
            nxt = m_total + 1;
            if ((nxt % DAYLEN) == 0 && (nxt / DAYLEN) >= lastday()) nxt = 0;
            m_total = nxt;
        end
        if (s) begin
            m_gap = 0;
            m_armed = 1;
        end else if (t && m_gap != LOSS) begin
            m_gap++;
        end
        if (valid) m_locked = 1;
        if (!s && m_gap == LOSS) begin
            m_locked = 0;
            m_armed = 0;
        end
    endtask

    task automatic compare();
        longint secs;
        int e_day, e_hour, e_min, e_sec, e_us;
        secs  = m_total / US;
        e_us  = int'(m_total % US);
        e_day = int'(secs / 86400) + 1;
        e_hour = int'((secs % 86400) / 3600);
        e_min = int'((secs % 3600) / 60);
        e_sec = int'(secs % 60);
        n_vec++;
        if (int'(day_o) != e_day || int'(hour_o) != e_hour || int'(min_o) != e_min
            || int'(sec_o) != e_sec || int'(usec_o) != e_us || locked_o != m_locked) begin
            n_bad++;
            $display("FAIL %s t=%0t: got %0d %0d:%0d:%0d.%0d lock=%0b, expected %0d %0d:%0d:%0d.%0d lock=%0b",
                     cur_req, $time, day_o, hour_o, min_o, sec_o, usec_o, locked_o,
                     e_day, e_hour, e_min, e_sec, e_us, m_locked);
        end
    endtask

    task automatic step(input bit t, input bit s);
        @(negedge clk);
        tick = t;
        pps  = s;
        @(posedge clk);
        model_edge(t, s);
        #2;
        compare();
    endtask

    task automatic set_preset(input int idx);
        case (idx)
            0: begin p_day = 9'd1;   p_hour = 5'd0;  p_min = 6'd0;  p_sec = 6'd0;  leap = 1'b0; end
            1: begin p_day = 9'd1;   p_hour = 5'd0;  p_min = 6'd0;  p_sec = 6'd59; leap = 1'b1; end
            2: begin p_day = 9'd42;  p_hour = 5'd13; p_min = 6'd59; p_sec = 6'd59; leap = 1'b0; end
            3: begin p_day = 9'd365; p_hour = 5'd23; p_min = 6'd59; p_sec = 6'd59; leap = 1'b0; end
            4: begin p_day = 9'd366; p_hour = 5'd23; p_min = 6'd59; p_sec = 6'd59; leap = 1'b1; end
            5: begin p_day = 9'd365; p_hour = 5'd23; p_min = 6'd59; p_sec = 6'd59; leap = 1'b1; end
            6: begin p_day = 9'd200; p_hour = 5'd23; p_min = 6'd59; p_sec = 6'd59; leap = 1'b0; end
            default: begin p_day = 9'd366; p_hour = 5'd23; p_min = 6'd59; p_sec = 6'd59; leap = 1'b0; end
        endcase
    endtask

    function automatic int ofs_val(input int idx);
        case (idx)
            0: return -20;
            1: return -1;
            2: return 0;
            3: return 1;
            default: return 37;
        endcase
    endfunction

    function automatic int gap_val(input int idx);
        case (idx)
            0: return US - TOL - 1;
            1: return US - TOL;
            2: return US;
            3: return US + TOL;
            default: return US + TOL + 1;
        endcase
    endfunction

    task automatic finish_run();
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: got no completion, expected completion");
        finish_run();
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        // R4: reset state
        cur_req = "R4";
        #1;
        compare();

        // R1 R10: freewheel from reset with occasional missing ticks
        cur_req = "R1 R10";
        for (int i = 0; i < 130; i++) step((i % 5) != 2, 1'b0);

        for (int oi = 0; oi < 5; oi++) begin
            for (int pi = 0; pi < 8; pi++) begin
                for (int gi = 0; gi < 5; gi++) begin
                    set_preset(pi);
                    ofs = OFS_W'(ofs_val(oi));
                    // R5: arming pulse loads nothing
                    cur_req = "R5";
                    step(1'b1, 1'b1);
                    for (int k = 0; k < gap_val(gi) - 1; k++) step(1'b1, 1'b0);
                    // R6 R7 R9 R11: loading pulse, tick in the same cycle
                    cur_req = "R5 R6 R7 R9 R11";
                    step(1'b1, 1'b1);
                    // R1 R2 R3 R10: carries through second, midnight and year end
                    cur_req = "R1 R2 R3 R10";
                    for (int k = 0; k < 70; k++) step((k % 7) != 3, 1'b0);
                    // R8: loss after 1.5 s, time keeps running
                    cur_req = "R8";
                    for (int k = 0; k < 20; k++) step(1'b1, 1'b0);
                end
            end
        end
        finish_run();
    end

endmodule